// File: doc/BRIEF.md
# Multi-register block transfer engine with base update

This block carries out one load-multiple or store-multiple operation of a 16-bit instruction set. When started, it receives a load/store select, a base register index, an 8-bit register-selection mask, the current base register value and the current program counter. It then walks the selected registers from the lowest index to the highest, moving one 32-bit word per clock between the register file and memory. The memory address starts at the base with its two low bits cleared and rises by four each word. At the end it writes an updated base back into the register file.

Three cases need care. A base value whose two low bits are not zero keeps those bits in the written-back base. A base register that is also in the mask changes both the stored data and whether write-back happens. An empty mask moves the program counter instead of any register and advances the base by 0x40. The engine reads the register file through an address/data pair, expects memory read data in the same cycle as the request, and marks each request as sequential or non-sequential so an outside timing model can cost it.

Top module: `lsm_engine`

## Requirements
- R1: Every memory request carries a word-aligned address (bits 1:0 zero) built from the base with its low two bits cleared; those two low bits are added back into the written-back base.
- R2: Selected registers move in ascending index order, one per cycle, with the address of the k-th word (k from 0) equal to the aligned base plus 4k; on a load the register written in that cycle is that k-th selected index and the data is the memory read data.
- R3: On a non-empty load, the cycle after the last word has no request and no register write; in the next cycle the base register is written with aligned base + 4n + low bits only when the base index is not in the mask, and nothing is written otherwise.
- R4: On a non-empty store, the base register is always written back with aligned base + 4n + low bits, in the cycle after the last word.
- R5: On a store where the base index is the lowest set bit of the mask, the word stored for it is the original base value, low bits included.
- R6: On a store where the base index is in the mask but is not its lowest set bit, the word stored for it is the final written-back base value.
- R7: With an empty mask and a load, exactly one word is read at the aligned base; the program counter load strobe and the flush strobe rise in that cycle, with the loaded value having bit 0 cleared.
- R8: With an empty mask and a store, exactly one word is written at the aligned base, its data being the start-time program counter plus 2.
- R9: With an empty mask, in either direction, the base is written back as aligned base + 0x40 + low bits in the cycle after the single transfer.
- R10: The first request of an operation is tagged non-sequential (seq = 0) and every later request of the same operation sequential (seq = 1).
- R11: Counting the start-sampling edge as cycle 0, done is high for exactly one cycle: cycle n+3 for a non-empty load, n+2 for a non-empty store, 3 for an empty mask; a start raised before done has ended is ignored.
- R12: After reset, no request, no register write, no program counter load and no done are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| load_i | input | 1 | 1 = load from memory, 0 = store to memory |
| base_idx_i | input | 3 | Index of the base register |
| rlist_i | input | 8 | Register selection mask, bit i selects register i |
| base_val_i | input | 32 | Current value of the base register |
| pc_i | input | 32 | Current program counter |
| rf_raddr_o | output | 3 | Register file read index |
| rf_rdata_i | input | 32 | Register file read data for rf_raddr_o, same cycle |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_seq_o | output | 1 | Request is sequential to the previous one |
| mem_addr_o | output | 32 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, same cycle as the request |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 3 | Register file write index |
| rf_wdata_o | output | 32 | Register file write data |
| pc_load_o | output | 1 | Load the program counter with pc_value_o |
| pc_value_o | output | 32 | New program counter value |
| flush_o | output | 1 | Flush the fetch pipeline |
| done_o | output | 1 | One-cycle end-of-operation pulse |

## Verification
The bench builds the engine with its default parameters: 32-bit data, an 8-entry register mask and an empty-mask step of 0x40. That width makes the full mask 0xFF and every base index reachable, so a base register can sit first, in the middle, last or outside the mask. The vectors also cover misaligned base values and both empty-mask directions. A start injected during a running operation checks that the accepted operation runs unchanged.

// File: rtl/lsm_pkg.sv
// Package: shared state encoding for the block transfer engine.
// Assumes: one operation in flight at a time.
package lsm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // waiting for start
        ST_XFER  = 3'd1,  // moving one selected register per cycle
        ST_EMPTY = 3'd2,  // single program-counter transfer for an empty mask
        ST_GAP   = 3'd3,  // internal cycle after the last loaded word
        ST_WB    = 3'd4,  // base write-back
        ST_DONE  = 3'd5   // completion pulse
    } lsm_state_e;
endpackage

// File: rtl/lsm_pick.sv
// Module: lsm_pick
// Finds the lowest set bit of a register mask, gives its index and the
// mask with that bit removed. Purely combinational.
// Assumes: LW is a power of two and IW = log2(LW).
module lsm_pick #(
    parameter int LW = 8,
    parameter int IW = $clog2(LW)
) (
    input  logic [LW-1:0] list_i,
    output logic [IW-1:0] idx_o,
    output logic [LW-1:0] rest_o
);
    logic [LW-1:0] low_oh;

    // isolate the lowest set bit as a one-hot vector
    assign low_oh = list_i & (~list_i + LW'(1));
    assign rest_o = list_i & ~low_oh;

    // encode the one-hot vector, one index bit per generate slice
    generate
        for (genvar b = 0; b < IW; b++) begin : g_enc
            logic [LW-1:0] sel;
            for (genvar i = 0; i < LW; i++) begin : g_sel
                if (((i >> b) & 1) == 1) begin : g_on
                    assign sel[i] = low_oh[i];
                end else begin : g_off
                    assign sel[i] = 1'b0;
                end
            end
            assign idx_o[b] = |sel;
        end
    endgenerate
endmodule

// File: rtl/lsm_addr.sv
// Module: lsm_addr
// Address unit: captures the aligned start address, the final base value
// (low bits preserved), the original base and the adjusted program counter
// at start, then steps the address by one word per transfer.
// Assumes: capture_i and step_i are never high together.
module lsm_addr #(
    parameter int DW         = 32,
    parameter int LW         = 8,
    parameter int STEP_EMPTY = 64,
    parameter int PC_ADJ     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_i,
    input  logic          step_i,
    input  logic [DW-1:0] base_i,
    input  logic [DW-1:0] pc_i,
    input  logic [LW-1:0] list_i,
    output logic [DW-1:0] addr_o,
    output logic [DW-1:0] final_o,
    output logic [DW-1:0] orig_o,
    output logic [DW-1:0] pc_store_o
);
    localparam int CW = $clog2(LW + 1);

    logic [CW-1:0] cnt;
    logic [DW-1:0] aligned, span, fin_next;
    logic [DW-1:0] addr_q, fin_q, orig_q, pcst_q;

    // count the selected registers
    always_comb begin
        cnt = '0;
        for (int i = 0; i < LW; i++) cnt = cnt + CW'(list_i[i]);
    end

    assign aligned  = {base_i[DW-1:2], 2'b00};
    assign span     = (cnt == '0) ? DW'(STEP_EMPTY) : (DW'(cnt) << 2);
    assign fin_next = aligned + span + DW'(base_i[1:0]);

    // hold operation addresses; advance the word address per transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            fin_q  <= '0;
            orig_q <= '0;
            pcst_q <= '0;
        end else if (capture_i) begin
            addr_q <= aligned;
            fin_q  <= fin_next;
            orig_q <= base_i;
            pcst_q <= pc_i + DW'(PC_ADJ);
        end else if (step_i) begin
            addr_q <= addr_q + DW'(4);
        end
    end

    assign addr_o     = addr_q;
    assign final_o    = fin_q;
    assign orig_o     = orig_q;
    assign pc_store_o = pcst_q;
endmodule

// File: rtl/lsm_ctrl.sv
// Module: lsm_ctrl
// Sequencer: accepts start only when idle, tracks the remaining mask,
// the first-transfer flag and how the base index relates to the mask.
// Assumes: rest_i is the remaining mask with its lowest bit removed.
module lsm_ctrl
    import lsm_pkg::*;
#(
    parameter int LW = 8,
    parameter int IW = $clog2(LW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          load_i,
    input  logic [IW-1:0] idx_i,
    input  logic [LW-1:0] list_i,
    input  logic [LW-1:0] rest_i,
    output lsm_state_e    state_o,
    output logic [LW-1:0] remain_o,
    output logic          load_o,
    output logic [IW-1:0] idx_o,
    output logic          first_o,
    output logic          base_in_o,
    output logic          base_first_o,
    output logic          capture_o,
    output logic          step_o
);
    lsm_state_e    state_q;
    logic [LW-1:0] remain_q;
    logic          load_q, first_q, base_in_q, base_first_q;
    logic [IW-1:0] idx_q;
    logic [LW-1:0] base_oh, below_mask;

    assign base_oh    = LW'(1) << idx_i;
    assign below_mask = base_oh - LW'(1);
    assign capture_o  = (state_q == ST_IDLE) && start_i;
    assign step_o     = (state_q == ST_XFER);

    // state sequencing and per-operation flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            remain_q     <= '0;
            load_q       <= 1'b0;
            idx_q        <= '0;
            first_q      <= 1'b0;
            base_in_q    <= 1'b0;
            base_first_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        remain_q     <= list_i;
                        load_q       <= load_i;
                        idx_q        <= idx_i;
                        first_q      <= 1'b1;
                        base_in_q    <= |(list_i & base_oh);
                        base_first_q <= (|(list_i & base_oh)) && ((list_i & below_mask) == '0);
                        state_q      <= (list_i == '0) ? ST_EMPTY : ST_XFER;
                    end
                end
                ST_XFER: begin
                    remain_q <= rest_i;
                    first_q  <= 1'b0;
                    if (rest_i == '0) state_q <= load_q ? ST_GAP : ST_WB;
                end
                ST_EMPTY: begin
                    first_q <= 1'b0;
                    state_q <= ST_WB;
                end
                ST_GAP:  state_q <= ST_WB;
                ST_WB:   state_q <= ST_DONE;
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o      = state_q;
    assign remain_o     = remain_q;
    assign load_o       = load_q;
    assign idx_o        = idx_q;
    assign first_o      = first_q;
    assign base_in_o    = base_in_q;
    assign base_first_o = base_first_q;
endmodule

// File: rtl/lsm_engine.sv
// Module: lsm_engine (top)
// Runs one load-multiple / store-multiple with increment-after addressing,
// one word per cycle, then writes the base back and pulses done.
// Assumes: register file read and memory read return data in the same cycle.
module lsm_engine
    import lsm_pkg::*;
#(
    parameter int DW         = 32,
    parameter int LW         = 8,
    parameter int STEP_EMPTY = 64,
    parameter int PC_ADJ     = 2,
    localparam int IW        = $clog2(LW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          load_i,
    input  logic [IW-1:0] base_idx_i,
    input  logic [LW-1:0] rlist_i,
    input  logic [DW-1:0] base_val_i,
    input  logic [DW-1:0] pc_i,
    output logic [IW-1:0] rf_raddr_o,
    input  logic [DW-1:0] rf_rdata_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic          mem_seq_o,
    output logic [DW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          rf_we_o,
    output logic [IW-1:0] rf_waddr_o,
    output logic [DW-1:0] rf_wdata_o,
    output logic          pc_load_o,
    output logic [DW-1:0] pc_value_o,
    output logic          flush_o,
    output logic          done_o
);
    lsm_state_e    state;
    logic [LW-1:0] remain, rest;
    logic [IW-1:0] pick_idx, idx_q;
    logic          load_q, first_q, base_in, base_first, capture, step;
    logic [DW-1:0] addr, fin, orig, pc_store;
    logic          in_xfer, in_empty, in_wb;

    lsm_ctrl #(.LW(LW), .IW(IW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .load_i(load_i),
        .idx_i(base_idx_i), .list_i(rlist_i), .rest_i(rest),
        .state_o(state), .remain_o(remain), .load_o(load_q), .idx_o(idx_q),
        .first_o(first_q), .base_in_o(base_in), .base_first_o(base_first),
        .capture_o(capture), .step_o(step)
    );

    lsm_pick #(.LW(LW), .IW(IW)) u_pick (
        .list_i(remain), .idx_o(pick_idx), .rest_o(rest)
    );

    lsm_addr #(.DW(DW), .LW(LW), .STEP_EMPTY(STEP_EMPTY), .PC_ADJ(PC_ADJ)) u_addr (
        .clk(clk), .rst_n(rst_n), .capture_i(capture), .step_i(step),
        .base_i(base_val_i), .pc_i(pc_i), .list_i(rlist_i),
        .addr_o(addr), .final_o(fin), .orig_o(orig), .pc_store_o(pc_store)
    );

    assign in_xfer  = (state == ST_XFER);
    assign in_empty = (state == ST_EMPTY);
    assign in_wb    = (state == ST_WB);

    // memory request side
    assign mem_req_o  = in_xfer || in_empty;
    assign mem_we_o   = !load_q;
    assign mem_seq_o  = in_xfer && !first_q;
    assign mem_addr_o = addr;
    assign rf_raddr_o = pick_idx;

    // store data: base register in the mask takes its original or final value
    always_comb begin
        if (in_empty)              mem_wdata_o = pc_store;
        else if (pick_idx == idx_q) mem_wdata_o = base_first ? orig : fin;
        else                       mem_wdata_o = rf_rdata_i;
    end

    // register file write: loaded words, then the base write-back
    assign rf_we_o    = (in_xfer && load_q) || (in_wb && !(load_q && base_in));
    assign rf_waddr_o = in_wb ? idx_q : pick_idx;
    assign rf_wdata_o = in_wb ? fin : mem_rdata_i;

    // program counter transfer for an empty mask on load
    assign pc_load_o  = in_empty && load_q;
    assign flush_o    = in_empty && load_q;
    assign pc_value_o = {mem_rdata_i[DW-1:1], 1'b0};

    assign done_o = (state == ST_DONE);
endmodule

// File: rtl/lsm_engine_chk.sv
// Module: lsm_engine_chk
// Protocol checker for lsm_engine, attached by bind below.
module lsm_engine_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic          mem_seq_o,
    input logic [DW-1:0] mem_addr_o,
    input logic          rf_we_o,
    input logic          pc_load_o,
    input logic [DW-1:0] pc_value_o,
    input logic          flush_o,
    input logic          done_o
);
    a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

    a_r2_addr_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && $past(mem_req_o)) |-> (mem_addr_o == $past(mem_addr_o) + DW'(4)));

    a_r10_first_nonseq: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !$past(mem_req_o)) |-> !mem_seq_o);

    a_r10_rest_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && $past(mem_req_o)) |-> mem_seq_o);

    a_r3_load_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_req_o) && !$past(mem_we_o) && !$past(pc_load_o)) |-> !rf_we_o);

    a_r7_flush_pc: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> (flush_o && !pc_value_o[0]));

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !mem_req_o));
endmodule

bind lsm_engine lsm_engine_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_seq_o(mem_seq_o), .mem_addr_o(mem_addr_o), .rf_we_o(rf_we_o),
    .pc_load_o(pc_load_o), .pc_value_o(pc_value_o), .flush_o(flush_o),
    .done_o(done_o)
);

// File: tb/lsm_engine_tb_top.sv
`timescale 1ns/1ps
module lsm_engine_tb_top;
    typedef struct packed {
        logic        ld;
        logic [2:0]  idx;
        logic [7:0]  lst;
        logic [31:0] base;
        logic [31:0] pc;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd0, 8'h0E, 32'h2000_0100, 32'h0800_0000},  // store, base outside
        '{1'b1, 3'd1, 8'h0E, 32'h2000_0203, 32'h0800_0000},  // load, base inside, misaligned
        '{1'b1, 3'd2, 8'h81, 32'h2000_0302, 32'h0800_0000},  // load, base outside
        '{1'b0, 3'd3, 8'h0F, 32'h2000_0401, 32'h0800_0000},  // store, base inside not first
        '{1'b0, 3'd2, 8'h34, 32'h2000_0500, 32'h0800_0000},  // store, base first
        '{1'b1, 3'd4, 8'h00, 32'h2000_0603, 32'h0800_1234},  // empty load
        '{1'b0, 3'd5, 8'h00, 32'h2000_0702, 32'h0800_2000},  // empty store
        '{1'b1, 3'd7, 8'hFF, 32'h2000_0800, 32'h0800_0000}   // full load
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, load_i = 1'b0;
    logic [2:0]  base_idx_i = '0;
    logic [7:0]  rlist_i = '0;
    logic [31:0] base_val_i = '0, pc_i = '0;
    logic [2:0]  rf_raddr_o, rf_waddr_o;
    logic [31:0] rf_rdata_i, mem_addr_o, mem_wdata_o, mem_rdata_i, rf_wdata_o, pc_value_o;
    logic        mem_req_o, mem_we_o, mem_seq_o, rf_we_o, pc_load_o, flush_o, done_o;
    logic [31:0] regs [8];

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'h5A00_00C3;
    endfunction

    assign mem_rdata_i = pat(mem_addr_o);
    assign rf_rdata_i  = regs[rf_raddr_o];

    lsm_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .load_i(load_i),
        .base_idx_i(base_idx_i), .rlist_i(rlist_i), .base_val_i(base_val_i),
        .pc_i(pc_i), .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_seq_o(mem_seq_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .pc_load_o(pc_load_o), .pc_value_o(pc_value_o), .flush_o(flush_o),
        .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int popc(input logic [7:0] l);
        int c = 0;
        for (int i = 0; i < 8; i++) c += int'(l[i]);
        return c;
    endfunction

    function automatic int nth(input logic [7:0] l, input int k);
        int c = 0;
        for (int i = 0; i < 8; i++) begin
            if (l[i]) begin
                if (c == k) return i;
                c++;
            end
        end
        return -1;
    endfunction

    // run one operation; inj > 0 raises a spurious start in that cycle
    task automatic run_op(input vec_t v, input int inj);
        int n, d, acc, bad_addr, bad_data, bad_seq, r;
        logic [31:0] al, fin, expd;
        logic wb_we [48];
        logic [2:0] wb_a [48];
        logic [31:0] wb_d [48];
        bit pc_seen;
        string dtag;
        n = popc(v.lst);
        al = {v.base[31:2], 2'b00};
        fin = al + ((n == 0) ? 32'h40 : 32'(4 * n)) + {30'd0, v.base[1:0]};
        for (int i = 0; i < 8; i++) regs[i] = 32'hC0DE_0000 | (i << 4);
        regs[v.idx] = v.base;
        d = 0; acc = 0; bad_addr = 0; bad_data = 0; bad_seq = 0; pc_seen = 0;
        if (n == 0) dtag = v.ld ? "R7" : "R8";
        else if (!v.ld && v.lst[v.idx]) dtag = (nth(v.lst, 0) == int'(v.idx)) ? "R5" : "R6";
        else dtag = "R2";

        @(negedge clk);
        load_i = v.ld; base_idx_i = v.idx; rlist_i = v.lst;
        base_val_i = v.base; pc_i = v.pc; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 1; c < 48; c++) begin
            #1;
            wb_we[c] = rf_we_o; wb_a[c] = rf_waddr_o; wb_d[c] = rf_wdata_o;
            if (mem_req_o) begin
                if (mem_addr_o != al + 32'(4 * acc)) bad_addr++;
                if (mem_seq_o != (acc != 0)) bad_seq++;
                if (mem_we_o != !v.ld) bad_data++;
                if (n == 0) begin
                    if (v.ld) begin
                        if (pc_load_o && flush_o && pc_value_o == (pat(al) & ~32'd1)) pc_seen = 1;
                    end else if (mem_wdata_o != v.pc + 32'd2) bad_data++;
                end else begin
                    r = nth(v.lst, acc);
                    if (v.ld) begin
                        if (!(rf_we_o && rf_waddr_o == 3'(r) && rf_wdata_o == pat(mem_addr_o))) bad_data++;
                    end else begin
                        if (r != int'(v.idx)) expd = regs[r];
                        else expd = (acc == 0) ? v.base : fin;
                        if (mem_wdata_o != expd) bad_data++;
                    end
                end
                acc++;
            end
            if (done_o) begin d = c; break; end
            if (inj > 0 && c == inj) begin
                start_i = 1'b1; load_i = !v.ld; rlist_i = 8'hFF; base_val_i = 32'h7777_7770;
            end else if (inj > 0 && c == inj + 1) begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(acc == ((n == 0) ? 1 : n) && bad_addr == 0, "R1", "access count/addresses", 32'(acc), 32'((n == 0) ? 1 : n));
        chk(bad_seq == 0, "R10", "seq tag mismatches", 32'(bad_seq), 0);
        chk(bad_data == 0, dtag, "data mismatches", 32'(bad_data), 0);
        chk(d == ((n == 0) ? 3 : (v.ld ? n + 3 : n + 2)), "R11", "done cycle", 32'(d),
            32'((n == 0) ? 3 : (v.ld ? n + 3 : n + 2)));
        if (n == 0 && v.ld) chk(pc_seen, "R7", "pc load with flush", 32'(pc_seen), 1);
        if (d > 1) begin
            if (v.ld && n > 0 && v.lst[v.idx]) begin
                chk(!wb_we[d-1], "R3", "no write-back when base in mask", 32'(wb_we[d-1]), 0);
            end else begin
                chk(wb_we[d-1] && wb_a[d-1] == v.idx && wb_d[d-1] == fin,
                    (n == 0) ? "R9" : (v.ld ? "R3" : "R4"), "write-back value", wb_d[d-1], fin);
            end
            if (v.ld && n > 0)
                chk(!wb_we[d-2], "R3", "gap cycle idle", 32'(wb_we[d-2]), 0);
        end
        if (inj > 0) begin
            int extra = 0;
            for (int c = 0; c < 4; c++) begin
                @(negedge clk); #1;
                if (mem_req_o || done_o) extra++;
            end
            chk(extra == 0, "R11", "no activity after ignored start", 32'(extra), 0);
        end
    endtask

    initial begin
        #(8ns * 100000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) regs[i] = '0;
        repeat (4) @(negedge clk);
        #1;
        chk(!mem_req_o && !rf_we_o && !pc_load_o && !done_o, "R12", "outputs in reset",
            {28'd0, mem_req_o, rf_we_o, pc_load_o, done_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!mem_req_o && !rf_we_o && !done_o, "R12", "idle after reset",
            {29'd0, mem_req_o, rf_we_o, done_o}, 0);

        for (int k = 0; k < NV; k++) run_op(VECS[k], 0);

        // directed: start raised while busy must be ignored (R11)
        run_op(VECS[0], 2);
        run_op(VECS[1], 3);
        // directed: back-to-back after done, misaligned empty store again (R9)
        run_op(VECS[6], 0);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule